// File: doc/BRIEF.md
# Paced Single-Channel DMA Transfer Engine

This block is one DMA channel that copies a programmed number of transfer cycles from a source address to a destination address. Software configures it through four 32-bit registers: source address, destination address, cycle count and control. Each cycle runs a read beat followed by a write beat on a single-beat master port. In burst mode a cycle is four read/write beat pairs.

After each beat pair, each endpoint address moves by its own signed step. Either endpoint can be held back by one of fifteen hardware request lines. Selector value zero leaves that endpoint unpaced. At each cycle boundary the channel pulses a one-clock grant on the selected lines.

When the count reaches zero the channel sets a finish flag. A bus error sets an error flag instead. In both cases the channel clears its own enable bit. The single interrupt output combines each flag with its enable.

Top module: `dma_xfer_chan`

## Requirements
- R1: After reset all four registers read zero, and `irq`, `m_valid` and `gnt_out` are low.
- R2: Register byte offsets (selected by `cfg_addr[3:2]`) are: source address 0, destination address 4, cycle count 8, control 12. The count register holds 24 bits, and bits 31:24 read back as zero.
- R3: Each beat reads the current source address with `m_write`=0, then writes the data just read to the current destination address with `m_write`=1. A beat completes on the clock edge where `m_valid` and `m_ready` are both high.
- R4: The count register decrements by one when a cycle's last write completes, and it can be read live during a transfer.
- R5: Each address advances after every completed write beat. The step is set by a 3-bit code: 000 none, 001 +1, 010 +2, 011 +4, 101 -1, 110 -2, 111 -4, and 100 none. The source code is control bits 10:8 and the destination code bits 14:12. Both address registers read back the advanced values.
- R6: With burst mode set (control bit 3), a cycle is four beats, so each address moves by four times its step per cycle.
- R7: When the count reaches zero, finish status (bit 1) is set and enable (bit 0) is cleared. Enabling with a count of zero finishes at once with no bus activity.
- R8: Pacing selectors are control bits 27:24 (source) and 19:16 (destination). A nonzero selector makes each cycle wait for `req_in` of that index to be high. At the end of each cycle, `gnt_out` pulses for one clock on each nonzero selected index. A selector of 0 means no wait.
- R9: Writing enable to 0 during a transfer stops the channel at the next cycle boundary. Finish status is not set, and no further beats or count changes occur.
- R10: A control write with a status bit at 0 clears that bit. Writing 1 to a status bit leaves it unchanged.
- R11: A bus error (`m_err` with `m_ready`) sets error status (bit 4), clears enable, ends the transfer, and leaves the count undecremented for the failed cycle.
- R12: `irq` is high exactly when (finish status and finish enable, bit 2) or (error status and error enable, bit 5).
- R13: `m_ahb` shows control bit 6 during read beats and bit 7 during write beats. `m_size` gives log2 bytes of the width field in bits 21:20: 00 gives 2, 01 gives 1, 10 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select, byte offset bits 3:2 |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| m_valid | output | 1 | Master beat request |
| m_write | output | 1 | Beat is a write |
| m_addr | output | 32 | Beat address |
| m_wdata | output | 32 | Write data |
| m_size | output | 2 | Beat size, log2 bytes |
| m_ahb | output | 1 | Bus side of the beat |
| m_rdata | input | 32 | Read data |
| m_ready | input | 1 | Beat accepted |
| m_err | input | 1 | Beat ended in error |
| req_in | input | LINES | Request lines, index 0 unused |
| gnt_out | output | LINES | Grant pulses |
| irq | output | 1 | Interrupt |

## Verification
Transfers are run four ways:
- An unpaced word copy with incrementing steps. This separates correct beat ordering and data forwarding from simple address arithmetic.
- A burst halfword copy with a decrementing source and a fixed destination. This distinguishes a per-beat step from a per-cycle step and checks sign handling.
- A byte copy paced on one request line, with the line held low and then pulsed. This shows that the wait gates beats, that the grant is a single clock, and that the count reads live. A disable in the middle of this transfer then shows stop-at-boundary without finish.
- A copy with an injected read error. This separates the error path from the finish path and shows the count left undecremented for the failed cycle.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int CNT_W = 24;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_READ, ST_WRITE} dmac_state_e;

    typedef struct packed {
        dmac_state_e       st;
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [CNT_W-1:0]  cnt;
        logic              en;
        logic              fin;
        logic              fin_ie;
        logic              burst;
        logic              err;
        logic              err_ie;
        logic              src_ahb;
        logic              dst_ahb;
        logic [2:0]        src_code;
        logic [2:0]        dst_code;
        logic [3:0]        src_line;
        logic [3:0]        dst_line;
        logic [1:0]        width;
        logic [1:0]        beat;
        logic [DW-1:0]     data;
    } chan_regs_t;

    function automatic logic [1:0] size_of(input logic [1:0] w);
        case (w)
            2'b01:   size_of = 2'd1;
            2'b10:   size_of = 2'd0;
            default: size_of = 2'd2;
        endcase
    endfunction
endpackage

// File: rtl/addr_step.sv
module addr_step
    import dmac_pkg::*;
(
    input  logic [2:0]    code,
    input  logic [AW-1:0] addr_cur,
    output logic [AW-1:0] addr_nxt
);
    logic [AW-1:0] mag;

    always_comb begin
        case (code[1:0])
            2'b01:   mag = AW'(1);
            2'b10:   mag = AW'(2);
            2'b11:   mag = AW'(4);
            default: mag = '0;
        endcase
        addr_nxt = code[2] ? (addr_cur - mag) : (addr_cur + mag);
    end

    always_comb begin
        if (code[1:0] != 2'b00) begin
            assert_step_moves_R5: assert (addr_nxt != addr_cur);
        end
    end
endmodule

// File: rtl/line_gate.sv
module line_gate #(
    parameter int LINES = 16
) (
    input  logic [3:0]       sel,
    input  logic [LINES-1:0] req,
    output logic             ok
);
    always_comb begin
        ok = 1'b1;
        if (sel != 4'd0) begin
            ok = (32'(sel) < LINES) ? req[sel] : 1'b0;
        end
    end
endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan
    import dmac_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:2]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             m_valid,
    output logic             m_write,
    output logic [31:0]      m_addr,
    output logic [31:0]      m_wdata,
    output logic [1:0]       m_size,
    output logic             m_ahb,
    input  logic [31:0]      m_rdata,
    input  logic             m_ready,
    input  logic             m_err,
    input  logic [LINES-1:0] req_in,
    output logic [LINES-1:0] gnt_out,
    output logic             irq
);
    chan_regs_t q, d;
    logic [AW-1:0] src_nxt, dst_nxt;
    logic src_ok, dst_ok;
    logic [1:0] last_beat;
    logic [31:0] ctrl_view;
    logic unused_wbits;

    assign unused_wbits = ^{cfg_wdata[31:28], cfg_wdata[23:22], cfg_wdata[15], cfg_wdata[11]};

    addr_step u_src_step (.code(q.src_code), .addr_cur(q.src), .addr_nxt(src_nxt));
    addr_step u_dst_step (.code(q.dst_code), .addr_cur(q.dst), .addr_nxt(dst_nxt));

    line_gate #(.LINES(LINES)) u_src_gate (.sel(q.src_line), .req(req_in), .ok(src_ok));
    line_gate #(.LINES(LINES)) u_dst_gate (.sel(q.dst_line), .req(req_in), .ok(dst_ok));

    assign last_beat = q.burst ? 2'd3 : 2'd0;

    assign ctrl_view = {4'b0, q.src_line, 2'b0, q.width, q.dst_line, 1'b0, q.dst_code,
                        1'b0, q.src_code, q.dst_ahb, q.src_ahb, q.err_ie, q.err,
                        q.burst, q.fin_ie, q.fin, q.en};

    always_comb begin
        case (cfg_addr)
            2'd0:    cfg_rdata = q.src;
            2'd1:    cfg_rdata = q.dst;
            2'd2:    cfg_rdata = 32'(q.cnt);
            default: cfg_rdata = ctrl_view;
        endcase
    end

    assign irq    = (q.fin & q.fin_ie) | (q.err & q.err_ie);
    assign m_size = size_of(q.width);

    always_comb begin
        d       = q;
        m_valid = 1'b0;
        m_write = 1'b0;
        m_addr  = '0;
        m_ahb   = 1'b0;
        m_wdata = q.data;
        gnt_out = '0;

        if (cfg_we) begin
            case (cfg_addr)
                2'd0: d.src = cfg_wdata;
                2'd1: d.dst = cfg_wdata;
                2'd2: d.cnt = cfg_wdata[CNT_W-1:0];
                default: begin
                    d.en       = cfg_wdata[0];
                    d.fin      = q.fin & cfg_wdata[1];
                    d.fin_ie   = cfg_wdata[2];
                    d.burst    = cfg_wdata[3];
                    d.err      = q.err & cfg_wdata[4];
                    d.err_ie   = cfg_wdata[5];
                    d.src_ahb  = cfg_wdata[6];
                    d.dst_ahb  = cfg_wdata[7];
                    d.src_code = cfg_wdata[10:8];
                    d.dst_code = cfg_wdata[14:12];
                    d.dst_line = cfg_wdata[19:16];
                    d.width    = cfg_wdata[21:20];
                    d.src_line = cfg_wdata[27:24];
                end
            endcase
        end

        case (q.st)
            ST_IDLE: begin
                if (q.en) begin
                    if (q.cnt == '0) begin
                        d.fin = 1'b1;
                        d.en  = 1'b0;
                    end else begin
                        d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                d.beat = 2'd0;
                if (!q.en) begin
                    d.st = ST_IDLE;
                end else if (src_ok && dst_ok) begin
                    d.st = ST_READ;
                end
            end
            ST_READ: begin
                m_valid = 1'b1;
                m_addr  = q.src;
                m_ahb   = q.src_ahb;
                if (m_ready) begin
                    if (m_err) begin
                        d.err = 1'b1;
                        d.en  = 1'b0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.data = m_rdata;
                        d.st   = ST_WRITE;
                    end
                end
            end
            default: begin
                m_valid = 1'b1;
                m_write = 1'b1;
                m_addr  = q.dst;
                m_ahb   = q.dst_ahb;
                if (m_ready) begin
                    if (m_err) begin
                        d.err = 1'b1;
                        d.en  = 1'b0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.src = src_nxt;
                        d.dst = dst_nxt;
                        if (q.beat == last_beat) begin
                            d.cnt = q.cnt - 1'b1;
                            for (int i = 1; i < LINES; i++) begin
                                gnt_out[i] = (q.src_line == 4'(i)) || (q.dst_line == 4'(i));
                            end
                            if (q.cnt == CNT_W'(1)) begin
                                d.fin = 1'b1;
                                d.en  = 1'b0;
                                d.st  = ST_IDLE;
                            end else begin
                                d.st = ST_WAIT;
                            end
                        end else begin
                            d.beat = q.beat + 2'd1;
                            d.st   = ST_READ;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    logic cnt_wr;
    assign cnt_wr = cfg_we && (cfg_addr == 2'd2);

    assert_cnt_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && !cnt_wr) |=> (q.cnt <= $past(q.cnt)));

    assert_grant_with_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt_out) && !cnt_wr) |=> (q.cnt == $past(q.cnt) - 1'b1));

    assert_paced_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_READ && $past(q.st) == ST_WAIT) |-> $past(src_ok && dst_ok));

    assert_fin_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.fin) |-> (!q.en && q.st == ST_IDLE));

    assert_err_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> (!q.en && q.st == ST_IDLE));
endmodule

// File: tb/test_dma_xfer_chan.sv
`timescale 1ns/1ps
module test_dma_xfer_chan;
    localparam int LINES = 16;
    localparam logic [31:0] KEY = 32'h5A5A_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:2] cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic m_valid, m_write, m_ahb;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [1:0] m_size;
    logic m_ready = 1'b1;
    logic m_err;
    logic [LINES-1:0] req_in = '0;
    logic [LINES-1:0] gnt_out;
    logic irq;

    logic err_arm = 1'b0;
    logic [31:0] err_addr = '0;
    logic exp_src_ahb = 1'b0, exp_dst_ahb = 1'b0;
    logic [1:0] exp_size = 2'd2;

    int checks = 0;
    int failures = 0;

    typedef struct packed { logic [31:0] a; logic [31:0] d; } beat_t;
    beat_t sb[$];

    always #4 clk = ~clk;

    assign m_rdata = m_addr ^ KEY;
    assign m_err   = err_arm && m_valid && !m_write && (m_addr == err_addr);

    dma_xfer_chan #(.LINES(LINES)) i_dma_xfer_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .m_valid(m_valid),
        .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata), .m_size(m_size),
        .m_ahb(m_ahb), .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err),
        .req_in(req_in), .gnt_out(gnt_out), .irq(irq)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = v; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    function automatic logic [31:0] stepv(input logic [2:0] c);
        logic [31:0] m;
        case (c[1:0])
            2'b01: m = 1; 2'b10: m = 2; 2'b11: m = 4; default: m = 0;
        endcase
        return c[2] ? -m : m;
    endfunction

    // driver side of the scoreboard: queue every expected write beat
    task automatic push_run(input logic [31:0] s0, input logic [31:0] d0, input logic [2:0] sc,
                            input logic [2:0] dc, input int beats);
        logic [31:0] s, dd;
        s = s0; dd = d0;
        for (int i = 0; i < beats; i++) begin
            sb.push_back({dd, s ^ KEY});
            s = s + stepv(sc);
            dd = dd + stepv(dc);
        end
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(2'd3, v);
            if (!v[0]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    // monitor: compare every accepted beat
    always @(negedge clk) begin
        #2;
        if (rst_n && m_valid && m_ready && !m_err) begin
            if (m_write) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3 unexpected write", m_addr, 32'h0);
                end else begin
                    beat_t e;
                    e = sb.pop_front();
                    check(m_addr == e.a, "R5 write address", m_addr, e.a);
                    check(m_wdata == e.d, "R3 write data", m_wdata, e.d);
                end
                check(m_ahb == exp_dst_ahb, "R13 write side", 32'(m_ahb), 32'(exp_dst_ahb));
                check(m_size == exp_size, "R13 size", 32'(m_size), 32'(exp_size));
            end else begin
                check(m_ahb == exp_src_ahb, "R13 read side", 32'(m_ahb), 32'(exp_src_ahb));
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] v;
        int bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 0, "R1 register reset", v, 0);
        end
        check(!irq && !m_valid && gnt_out == 0, "R1 outputs idle", {irq, m_valid, 30'(gnt_out)}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;

        // R2 register map
        wr(2'd0, 32'h1000); wr(2'd1, 32'h2000); wr(2'd2, 32'hFF00_0003);
        rd(2'd0, v); check(v == 32'h1000, "R2 source reg", v, 32'h1000);
        rd(2'd1, v); check(v == 32'h2000, "R2 dest reg", v, 32'h2000);
        rd(2'd2, v); check(v == 32'h3, "R2 count 24 bits", v, 32'h3);

        // unpaced word copy, +4/+4 (R3 R4 R5 R7 R12)
        exp_src_ahb = 1; exp_dst_ahb = 0; exp_size = 2'd2;
        push_run(32'h1000, 32'h2000, 3'b011, 3'b011, 3);
        wr(2'd3, 32'h0000_3345);
        wait_done();
        rd(2'd3, v); check(v == 32'h3346, "R7 finish sets and clears enable", v, 32'h3346);
        rd(2'd2, v); check(v == 0, "R4 count at end", v, 0);
        rd(2'd0, v); check(v == 32'h100C, "R5 source advanced", v, 32'h100C);
        rd(2'd1, v); check(v == 32'h200C, "R5 dest advanced", v, 32'h200C);
        check(irq == 1, "R12 finish irq", 32'(irq), 1);
        check(sb.size() == 0, "R3 all beats seen", sb.size(), 0);

        // R10 status write semantics
        wr(2'd3, 32'h3346);
        rd(2'd3, v); check(v[1] == 1, "R10 writing one keeps finish", v, 32'h3346);
        wr(2'd3, 32'h3344);
        rd(2'd3, v); check(v[1] == 0, "R10 writing zero clears finish", v, 32'h3344);
        check(irq == 0, "R12 irq drops", 32'(irq), 0);

        // burst halfword, src -2, dst fixed (R6)
        exp_src_ahb = 0; exp_dst_ahb = 1; exp_size = 2'd1;
        wr(2'd0, 32'h3000); wr(2'd1, 32'h4000); wr(2'd2, 32'h2);
        push_run(32'h3000, 32'h4000, 3'b110, 3'b000, 8);
        wr(2'd3, 32'h0010_0689);
        wait_done();
        rd(2'd0, v); check(v == 32'h2FF0, "R6 burst source moved 4x step per cycle", v, 32'h2FF0);
        rd(2'd1, v); check(v == 32'h4000, "R5 fixed destination", v, 32'h4000);
        rd(2'd3, v); check(v == 32'h0010_068A, "R7 burst finish", v, 32'h0010_068A);
        check(irq == 0, "R12 no irq without enable", 32'(irq), 0);
        check(sb.size() == 0, "R6 eight beats seen", sb.size(), 0);
        wr(2'd3, 32'h0010_0688);

        // paced byte copy on line 3 (R8 R4 R9)
        exp_src_ahb = 0; exp_dst_ahb = 0; exp_size = 2'd0;
        wr(2'd0, 32'h5000); wr(2'd1, 32'h6000); wr(2'd2, 32'h2);
        push_run(32'h5000, 32'h6000, 3'b001, 3'b010, 1);
        wr(2'd3, 32'h0320_2101);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #2;
            if (m_valid) bad++;
        end
        check(bad == 0, "R8 waits for request", bad, 0);
        req_in[3] = 1'b1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); #2;
            if (gnt_out != 0) break;
        end
        check(gnt_out == 16'h0008, "R8 grant on line 3", 32'(gnt_out), 32'h8);
        req_in[3] = 1'b0;
        @(negedge clk); #2;
        check(gnt_out == 0, "R8 grant one clock", 32'(gnt_out), 0);
        repeat (5) @(negedge clk);
        rd(2'd2, v); check(v == 1, "R4 live count", v, 1);
        wr(2'd3, 32'h0320_2100);
        repeat (5) @(negedge clk);
        req_in[3] = 1'b1;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #2;
            if (m_valid) bad++;
        end
        req_in[3] = 1'b0;
        check(bad == 0, "R9 no beats after disable", bad, 0);
        rd(2'd2, v); check(v == 1, "R9 count held", v, 1);
        rd(2'd3, v); check(v == 32'h0320_2100, "R9 no finish on stop", v, 32'h0320_2100);
        rd(2'd0, v); check(v == 32'h5001, "R5 +1 step", v, 32'h5001);
        rd(2'd1, v); check(v == 32'h6002, "R5 +2 step", v, 32'h6002);

        // zero count start (R7)
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h5);
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #2;
            if (m_valid) bad++;
        end
        rd(2'd3, v); check(v == 32'h6 && bad == 0, "R7 zero count finishes at once", v, 32'h6);
        wr(2'd3, 32'h4);

        // read error (R11 R12 R10)
        exp_src_ahb = 0; exp_dst_ahb = 0; exp_size = 2'd2;
        err_arm = 1'b1; err_addr = 32'h7008;
        wr(2'd0, 32'h7000); wr(2'd1, 32'h8000); wr(2'd2, 32'h5);
        push_run(32'h7000, 32'h8000, 3'b011, 3'b011, 2);
        wr(2'd3, 32'h3321);
        wait_done();
        rd(2'd3, v); check(v == 32'h3330, "R11 error status, enable cleared", v, 32'h3330);
        rd(2'd2, v); check(v == 3, "R11 count not decremented", v, 3);
        check(irq == 1, "R12 error irq", 32'(irq), 1);
        check(sb.size() == 0, "R11 beats before error", sb.size(), 0);
        err_arm = 1'b0;
        wr(2'd3, 32'h3320);
        rd(2'd3, v); check(v == 32'h3320, "R10 error cleared", v, 32'h3320);
        check(irq == 0, "R12 irq after clear", 32'(irq), 0);

        summary();
    end
endmodule